// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over 32 clock cycles and returns a 64-bit product. Each cycle it retires one bit of the multiplier. The multiplier operand does not get its own register. It is placed in the lower half of a single double-width accumulator. A single-width adder updates only the upper half. The whole accumulator then shifts right by one place, so the consumed multiplier bits drop out as product bits enter.

Each operation picks its own mode. In unsigned mode, the adder carry becomes the bit shifted in at the top. In signed (two's-complement) mode, the shift copies the sign. The last iteration also subtracts the multiplicand when the multiplier's sign bit is set. A caller pulses `start` with both operands and the mode, and waits for the one-cycle `done` pulse. The caller then reads the product as separate high and low words. Any overflow beyond 64 bits is ignored.

Top module: `shift_add_mul`

## Requirements
- R1: A `start` pulse while idle captures both operands and the mode on that clock edge, and `busy` is high in the following cycle.
- R2: With `is_signed` = 0, the operands are unsigned and {`res_hi`,`res_lo`} equals their exact 64-bit unsigned product.
- R3: With `is_signed` = 1, the operands are two's-complement and {`res_hi`,`res_lo`} equals their exact 64-bit two's-complement product.
- R4: `busy` stays high for exactly 32 cycles. `done` rises on the edge that ends the 32nd iteration, which is the 33rd cycle counted from the cycle after the capturing edge. `busy` and `done` are never high together.
- R5: `done` is high for exactly one cycle per operation.
- R6: A `start` pulse while `busy` is high is ignored. The running operation completes with its original operands, and its timing is unchanged.
- R7: After `done`, `res_hi`, `res_lo` and `busy` keep their values until the next accepted `start`.
- R8: After a synchronous active-low reset, `busy`, `done`, `res_hi` and `res_lo` are all zero.
- R9: The extreme operands give exact results. These are 0x80000000 squared in signed mode (0x4000000000000000), 0xFFFFFFFF squared in unsigned mode (0xFFFFFFFE00000001), the signed product of -1 and 0x80000000, and a zero operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while idle) |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand_in | input | 32 | Multiplicand |
| mplier_in | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| res_hi | output | 32 | Product bits 63:32 |
| res_lo | output | 32 | Product bits 31:0 |

## Verification
The assertions assume that `start` may arrive in any cycle, including while busy. They also assume the operands matter only on an accepted start, and that reset is held for at least one edge before stimulus begins. The bench respects these assumptions. It drives all inputs at the falling edge and holds reset low for several cycles. It deliberately pulses `start` with unrelated operands in the middle of a run to exercise the ignore path. The random operands come from a fixed seed. Directed cases cover the sign and width extremes.

// File: rtl/mul_pkg.sv
// Package: shared width and mode encoding for the shift-add multiplier.
// Assumes: nothing beyond a positive operand width.
package mul_pkg;
    localparam int unsigned OP_W = 32;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;
endpackage

// File: rtl/mul_seq_ctrl.sv
// Control sequencer: accepts start while idle, counts WIDTH iterations,
// and raises a one-cycle done pulse after the last one.
// Assumes: start is synchronous to clk; WIDTH >= 2.
module mul_seq_ctrl #(
    parameter int unsigned WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    // Purpose: decode the load, step and final-iteration strobes.
    always_comb begin
        load = start && !busy_q;
        step = busy_q;
        last = busy_q && (cnt_q == CNT_LAST);
    end

    // Purpose: iteration counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (last) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    a_r4_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));
    a_r1_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy_q);
endmodule

// File: rtl/mul_seq_datapath.sv
// Datapath: holds the multiplicand and one double-width accumulator whose
// low half starts as the multiplier. Each step conditionally adds (or, on
// the last signed step, subtracts) the multiplicand into the high half
// through a WIDTH+1 bit adder, then shifts the whole accumulator right.
// Assumes: load and step are never high together.
module mul_seq_datapath #(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic               mode_in,
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    output logic [2*WIDTH-1:0] prod
);
    import mul_pkg::*;

    localparam int unsigned PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    mul_mode_e        mode_q;
    logic [WIDTH:0]   hi_ext;
    logic [WIDTH:0]   mc_ext;
    logic [WIDTH:0]   acc;

    // Purpose: extend the high half and multiplicand to WIDTH+1 bits by mode.
    always_comb begin
        hi_ext = {(mode_q == MODE_SIGNED) && prod_q[PW-1], prod_q[PW-1:WIDTH]};
        mc_ext = {(mode_q == MODE_SIGNED) && mcand_q[WIDTH-1], mcand_q};
    end

    // Purpose: select add, subtract (final signed step) or pass-through.
    always_comb begin
        if (!prod_q[0])
            acc = hi_ext;
        else if (last && (mode_q == MODE_SIGNED))
            acc = hi_ext - mc_ext;
        else
            acc = hi_ext + mc_ext;
    end

    // Purpose: operand capture and per-iteration add-and-shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
            mode_q  <= MODE_UNSIGNED;
        end else if (load) begin
            mcand_q <= a_in;
            prod_q  <= {{WIDTH{1'b0}}, b_in};
            mode_q  <= mul_mode_e'(mode_in);
        end else if (step) begin
            prod_q <= {acc, prod_q[WIDTH-1:1]};
        end
    end

    assign prod = prod_q;

    a_r1_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_q[WIDTH-1:0] == $past(b_in)) && (prod_q[PW-1:WIDTH] == '0));
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(prod_q));
    a_r6_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
// Top: sequential shift-add multiplier, WIDTH x WIDTH -> 2*WIDTH bits,
// unsigned or two's-complement per operation, WIDTH cycles per product.
// Assumes: operands are sampled only on an accepted start.
module shift_add_mul #(
    parameter int unsigned WIDTH = mul_pkg::OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [WIDTH-1:0] mplier_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] res_hi,
    output logic [WIDTH-1:0] res_lo
);
    logic             load;
    logic             step;
    logic             last;
    logic [2*WIDTH-1:0] prod;

    mul_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    mul_seq_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .last    (last),
        .mode_in (is_signed),
        .a_in    (mcand_in),
        .b_in    (mplier_in),
        .prod    (prod)
    );

    assign res_hi = prod[2*WIDTH-1:WIDTH];
    assign res_lo = prod[WIDTH-1:0];

    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(res_hi) && $stable(res_lo)));
endmodule

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] mcand_in = '0;
    logic [31:0] mplier_in = '0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;  // 125 MHz

    shift_add_mul u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .mcand_in(mcand_in), .mplier_in(mplier_in),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [63:0] exp_prod(input logic [31:0] a, input logic [31:0] b,
                                             input logic sgn);
        logic signed [63:0] sa, sb;
        if (sgn) begin
            sa = $signed({{32{a[31]}}, a});
            sb = $signed({{32{b[31]}}, b});
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                          input bit disturb, input string tag);
        int cyc;
        logic [63:0] e;
        e = exp_prod(a, b, sgn);
        @(negedge clk);
        start = 1'b1; is_signed = sgn; mcand_in = a; mplier_in = b;
        @(negedge clk);
        start = 1'b0; mcand_in = ~a; mplier_in = b ^ 32'h5A5A_1234; is_signed = ~sgn;
        check(busy === 1'b1, "R1 busy after start", 64'(busy), 64'd1);
        cyc = 1;
        while (done !== 1'b1 && cyc < 100) begin
            if (disturb && cyc == 10) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (busy === 1'b1 && done === 1'b1) check(0, "R4 busy and done together", 64'd1, 64'd0);
        end
        check(cyc == 33, {"R4 done latency ", tag}, 64'(cyc), 64'd33);
        check({res_hi, res_lo} === e, {sgn ? "R3 signed " : "R2 unsigned ", tag},
              {res_hi, res_lo}, e);
        if (disturb) check({res_hi, res_lo} === e, "R6 start while busy ignored",
                           {res_hi, res_lo}, e);
        @(negedge clk);
        check(done === 1'b0, "R5 done single cycle", 64'(done), 64'd0);
        repeat (2) @(negedge clk);
        check({res_hi, res_lo} === e && busy === 1'b0, "R7 result held",
              {res_hi, res_lo}, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && {res_hi, res_lo} === 64'd0,
              "R8 reset state", {res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;

        run_op(32'd7, 32'd2, 1'b0, 0, "small");
        run_op(32'hFFFF_FFF9, 32'd2, 1'b1, 0, "neg x pos");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R9 min squared");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R9 max squared");
        run_op(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 0, "R9 minus one x min");
        run_op(32'd0, 32'hDEAD_BEEF, 1'b1, 0, "R9 zero operand");
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1, "disturbed unsigned");
        run_op(32'h8765_4321, 32'hF000_000F, 1'b1, 1, "disturbed signed");

        for (int i = 0; i < 40; i++) begin
            run_op($urandom, $urandom, 1'($urandom), (i % 5) == 0, "random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule